// File: doc/BRIEF.md
# Half-Duplex Clocked Programming Link Engine

This block is the master end of a two-wire, clocked, half-duplex serial link used to program a small target device. It divides the system clock down to a continuous link clock and owns one shared data line. Bytes travel in 12-bit frames. Each frame is a low start bit, eight data bits least significant first, an even-parity bit and two high stop bits. The engine drives the line on falling link-clock edges and samples it on rising edges.

Raising `session_en` starts a session. The engine pulls the target reset low, holds it there, and sends two all-high frames so that the target sees more than 16 idle bits. It then raises `tx_ready`. Lowering `session_en` ends the session at once: the reset line is released, and the clock and data lines are tristated and parked low.

The host side has three request types. A byte send uses `tx_valid`/`tx_ready`: a byte moves on a clock edge where both are high, and `tx_valid` with `tx_data` must stay stable until that edge. A receive request on `rx_req` and an idle-frame request on `idle_req` are taken only on an edge where `tx_ready` is high. If several requests arrive together, a send wins over an idle frame, and an idle frame wins over a receive. `tx_ready` stays low while any frame is on the line, and this is the only back-pressure. A received byte comes out on `rx_valid` for exactly one cycle, with no back-pressure.

Top module: `prog_link_engine`

## Requirements
- R1: A sent byte d appears on the line as 12 bits, first to last: 0, d[0]..d[7], the XOR of all bits of d, 1, 1.
- R2: While the data line is driven, `data_out` changes only in the cycle where `link_clk` falls, so it is stable through every high phase of `link_clk`.
- R3: In receive, the line is sampled at each rising edge of `link_clk`. High samples taken before the first low sample are skipped and do not count as frame bits.
- R4: After the 12th sampled bit of a received frame, `rx_valid` is high for exactly one cycle. `rx_data` then holds sampled bits 1..8, with bit 1 as the LSB.
- R5: `rx_err` is high together with `rx_valid` when bits 1..9 of the received frame hold an odd number of ones, or when either of bits 10 and 11 is 0. Otherwise `rx_err` is low.
- R6: On session entry, `tgt_rst_n` goes low on the next clock edge. At least 24 rising edges of `link_clk` then pass with the data line driven high before `tx_ready` first rises.
- R7: When `session_en` is low, `tgt_rst_n` is 1 and `data_oe`, `clk_oe` and `link_clk` are 0, from the next clock edge onward.
- R8: `tx_ready` is low from the edge that accepts a request until the frame it starts has finished, including the half bit after the last stop bit.
- R9: When the line turns to transmit, `data_out` is already 1 in the first cycle with `data_oe` high. When it turns to receive, `data_oe` drops only after the previous frame has finished.
- R10: An idle-frame request drives the data line high, with `data_oe` high, for 12 consecutive rising edges of `link_clk`.
- R11: During a session, `link_clk` toggles every HALF_DIV system cycles.
- R12: After reset, `tgt_rst_n` is 1 and `data_oe`, `clk_oe`, `link_clk`, `tx_ready` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| session_en | input | 1 | High to hold a programming session open |
| tx_valid | input | 1 | Byte to send is offered |
| tx_ready | output | 1 | Engine can take a send, receive or idle request |
| tx_data | input | DATA_W | Byte to send |
| rx_req | input | 1 | Request to receive one byte |
| idle_req | input | 1 | Request to send one all-high frame |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | DATA_W | Received byte |
| rx_err | output | 1 | Parity or stop-bit fault in the received frame |
| tgt_rst_n | output | 1 | Target reset, low for the whole session |
| link_clk | output | 1 | Link clock |
| clk_oe | output | 1 | Output enable for the link clock pin |
| data_out | output | 1 | Data line drive value |
| data_oe | output | 1 | Output enable for the data line |
| data_in | input | 1 | Data line sense value |

## Verification
A request is accepted on the edge where `tx_ready` is high. `tx_ready` and the turnaround of `data_oe` are due by the following negative clock edge, and the bench checks them there. Sent bits first appear at the next falling `link_clk`, so the bench reads each bit one cycle after a rising `link_clk` and reads it again just before the following fall. Received bits are driven one cycle after each falling `link_clk`, and `rx_valid` is due in the cycle after the 12th rising edge, so the bench polls every negative edge and has a bounded timeout. Session entry and exit take effect on the next edge and are checked one cycle after `session_en` changes.

// File: rtl/prog_link_pkg.sv
package prog_link_pkg;
  // Session sequencing states
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RST  = 2'd1,
    ST_IDLE = 2'd2,
    ST_RUN  = 2'd3
  } link_state_e;

  localparam int STOP_BITS = 2;
  localparam int OVERHEAD  = 2 + STOP_BITS; // start + parity + stops
endpackage

// File: rtl/plk_clkgen.sv
module plk_clkgen #(
  parameter int HALF_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic lclk,
  output logic tick_rise,
  output logic tick_fall
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic          term;

  assign term      = en && (div_q == LAST);
  assign tick_rise = term && !lclk;
  assign tick_fall = term && lclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      lclk  <= 1'b0;
    end else if (!en) begin
      div_q <= '0;
      lclk  <= 1'b0;
    end else if (term) begin
      div_q <= '0;
      lclk  <= !lclk;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/plk_tx_shifter.sv
module plk_tx_shifter #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               tick_rise,
  input  logic               tick_fall,
  output logic               bit_out,
  output logic               busy
);
  localparam int CW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_W);

  logic [FRAME_W-1:0] sh_q;
  logic [CW-1:0]      cnt_q;
  logic               tail_q;   // last bit still being held for the target

  assign busy = (cnt_q != '0) || tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '1;
      cnt_q   <= '0;
      tail_q  <= 1'b0;
      bit_out <= 1'b1;
    end else if (clr) begin
      sh_q    <= '1;
      cnt_q   <= '0;
      tail_q  <= 1'b0;
      bit_out <= 1'b1;
    end else if (load) begin
      sh_q   <= frame;
      cnt_q  <= FULL;
      tail_q <= 1'b0;
    end else if (tick_fall && cnt_q != '0) begin
      bit_out <= sh_q[0];
      sh_q    <= {1'b1, sh_q[FRAME_W-1:1]};
      cnt_q   <= cnt_q - 1'b1;
      tail_q  <= (cnt_q == CW'(1));
    end else if (tick_rise && tail_q) begin
      tail_q <= 1'b0;
    end
  end
endmodule

// File: rtl/plk_rx_shifter.sv
module plk_rx_shifter #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              arm,
  input  logic              tick_rise,
  input  logic              din,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              err
);
  localparam int CW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_W);

  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] nxt;
  logic [CW-1:0]      cnt_q;
  logic               hunting;

  assign busy    = (cnt_q != '0);
  assign hunting = (cnt_q == FULL);
  assign nxt     = {din, sh_q[FRAME_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      valid <= 1'b0;
      data  <= '0;
      err   <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      valid <= 1'b0;
      err   <= 1'b0;
    end else begin
      valid <= 1'b0;
      err   <= 1'b0;
      if (arm) begin
        cnt_q <= FULL;
      end else if (tick_rise && busy && !(hunting && din)) begin
        sh_q  <= nxt;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          valid <= 1'b1;
          data  <= nxt[DATA_W:1];
          err   <= (^nxt[DATA_W+1:1]) || !(&nxt[FRAME_W-1:DATA_W+2]);
        end
      end
    end
  end
endmodule

// File: rtl/prog_link_engine.sv
module prog_link_engine
  import prog_link_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 8,
  parameter int RST_HOLD    = 16,
  parameter int IDLE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              session_en,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_req,
  input  logic              idle_req,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_err,
  output logic              tgt_rst_n,
  output logic              link_clk,
  output logic              clk_oe,
  output logic              data_out,
  output logic              data_oe,
  input  logic              data_in
);
  localparam int FRAME_W = DATA_W + OVERHEAD;
  localparam int HW      = $clog2(RST_HOLD + 1);
  localparam int BW      = $clog2(IDLE_FRAMES + 1);

  link_state_e     state_q;
  logic [HW-1:0]   hold_q;
  logic [BW-1:0]   idles_left_q;
  logic            dir_tx_q;

  logic lclk, tick_rise, tick_fall;
  logic tx_busy, rx_busy, tx_bit;
  logic active, ready, tx_load, rx_arm, idle_load;
  logic [FRAME_W-1:0] frame;

  assign active    = (state_q != ST_OFF);
  assign ready     = (state_q == ST_RUN) && session_en && !tx_busy && !rx_busy;
  assign idle_load = (state_q == ST_IDLE) && session_en && !tx_busy && (idles_left_q != '0);
  assign tx_load   = idle_load || (ready && (tx_valid || idle_req));
  assign rx_arm    = ready && !tx_valid && !idle_req && rx_req;
  assign frame     = (ready && tx_valid)
                     ? {{STOP_BITS{1'b1}}, ^tx_data, tx_data, 1'b0}
                     : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_OFF;
      hold_q       <= '0;
      idles_left_q <= '0;
      dir_tx_q     <= 1'b1;
    end else if (!session_en) begin
      state_q  <= ST_OFF;
      dir_tx_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_q  <= ST_RST;
          hold_q   <= '0;
          dir_tx_q <= 1'b1;
        end
        ST_RST: begin
          hold_q <= hold_q + 1'b1;
          if (hold_q == HW'(RST_HOLD - 1)) begin
            state_q      <= ST_IDLE;
            idles_left_q <= BW'(IDLE_FRAMES);
          end
        end
        ST_IDLE: begin
          if (!tx_busy) begin
            if (idles_left_q != '0) idles_left_q <= idles_left_q - 1'b1;
            else                    state_q      <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (ready) begin
            if (tx_valid || idle_req) dir_tx_q <= 1'b1;
            else if (rx_req)          dir_tx_q <= 1'b0;
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  plk_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(active),
    .lclk(lclk), .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  plk_tx_shifter #(.FRAME_W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(!active), .load(tx_load), .frame(frame),
    .tick_rise(tick_rise), .tick_fall(tick_fall),
    .bit_out(tx_bit), .busy(tx_busy)
  );

  plk_rx_shifter #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(!active), .arm(rx_arm),
    .tick_rise(tick_rise), .din(data_in),
    .busy(rx_busy), .valid(rx_valid), .data(rx_data), .err(rx_err)
  );

  assign tx_ready  = ready;
  assign tgt_rst_n = !active;
  assign clk_oe    = active;
  assign link_clk  = lclk && active;
  assign data_oe   = active && dir_tx_q;
  assign data_out  = dir_tx_q ? tx_bit : 1'b1;
endmodule

// File: rtl/prog_link_checker.sv
module prog_link_checker (
  input logic clk,
  input logic rst_n,
  input logic session_en,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_err,
  input logic tgt_rst_n,
  input logic link_clk,
  input logic clk_oe,
  input logic data_out,
  input logic data_oe
);
  assert_data_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe) && !$stable(data_out)) |-> $fell(link_clk));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_err_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_valid);

  assert_not_ready_at_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_rst_n) |-> !tx_ready);

  assert_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst_n |-> (!link_clk && !data_oe));

  assert_exit_next_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !session_en |=> tgt_rst_n);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_clock_in_session_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_clk) |-> clk_oe);
endmodule

bind prog_link_engine prog_link_checker u_chk (
  .clk(clk), .rst_n(rst_n), .session_en(session_en),
  .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_err(rx_err), .tgt_rst_n(tgt_rst_n),
  .link_clk(link_clk), .clk_oe(clk_oe),
  .data_out(data_out), .data_oe(data_oe)
);

// File: tb/prog_link_engine_test.sv
`timescale 1ns/1ps
module prog_link_engine_test;
  localparam int HD = 4;
  localparam int FW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic session_en = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic rx_req = 1'b0;
  logic idle_req = 1'b0;
  logic data_in = 1'b1;
  logic tx_ready, rx_valid, rx_err, tgt_rst_n, link_clk, clk_oe, data_out, data_oe;
  logic [7:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  prog_link_engine #(.DATA_W(8), .HALF_DIV(HD), .RST_HOLD(6), .IDLE_FRAMES(2)) uut (
    .clk(clk), .rst_n(rst_n), .session_en(session_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_req(rx_req), .idle_req(idle_req),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .tgt_rst_n(tgt_rst_n), .link_clk(link_clk), .clk_oe(clk_oe),
    .data_out(data_out), .data_oe(data_oe), .data_in(data_in)
  );

  // kind[11:10]: 0 send, 1 receive good, 2 receive bad parity, 3 receive bad stop
  // [9:8]: idle-high lead bits minus one (receive), [7:0]: byte
  localparam logic [11:0] VEC [10] = '{
    12'h0A5, 12'h000, 12'h63C, 12'h4FF, 12'h080,
    12'h912, 12'h07E, 12'hD01, 12'h700, 12'h0FF
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk_frame(input logic [7:0] d, input int kind);
    logic [11:0] f;
    f = {2'b11, ^d, d, 1'b0};
    if (kind == 2) f[9] = !f[9];
    if (kind == 3) f[11] = 1'b0;
    return f;
  endfunction

  task automatic wait_ready();
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic do_tx(input logic [7:0] d);
    logic [11:0] got;
    logic v, stable_ok;
    int k;
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    wait_ready();
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!tx_ready, "R8 busy after send accept", tx_ready, 0);
    chk(data_oe && data_out, "R9 line high at enable", {data_oe, data_out}, 2'b11);
    got = '1; stable_ok = 1'b1;
    k = 0; v = 1'b1;
    while (v && k < 3*FW) begin
      @(posedge link_clk); #1 v = data_out; k++;
    end
    for (int i = 0; i < FW; i++) begin
      if (i > 0) begin @(posedge link_clk); #1 v = data_out; end
      got[i] = v;
      repeat (HD) @(negedge clk);
      if (data_out !== v || !data_oe) stable_ok = 1'b0;
    end
    chk(got == mk_frame(d, 0), "R1 sent frame", got, mk_frame(d, 0));
    chk(stable_ok, "R2 bit stable in high phase", stable_ok, 1);
  endtask

  task automatic drive_bits(input logic [11:0] f, input int lead);
    for (int i = 0; i < lead; i++) begin
      @(negedge link_clk); @(negedge clk); data_in = 1'b1;
    end
    for (int i = 0; i < FW; i++) begin
      @(negedge link_clk); @(negedge clk); data_in = f[i];
    end
    @(negedge link_clk); @(negedge clk); data_in = 1'b1;
  endtask

  task automatic do_rx(input logic [7:0] d, input int kind, input int lead);
    logic got;
    logic [7:0] gd;
    logic ge;
    got = 1'b0; gd = '0; ge = 1'b0;
    @(negedge clk);
    wait_ready();
    rx_req = 1'b1;
    @(negedge clk);
    rx_req = 1'b0;
    chk(!data_oe, "R9 line released for receive", data_oe, 0);
    fork
      drive_bits(mk_frame(d, kind), lead);
      begin
        for (int k = 0; k < 40*HD*FW && !got; k++) begin
          @(negedge clk);
          if (rx_valid) begin got = 1'b1; gd = rx_data; ge = rx_err; end
        end
      end
    join
    chk(got, "R3 frame found after idle bits", got, 1);
    chk(gd == d, "R4 received byte", gd, d);
    chk(ge == (kind >= 2), "R5 error flag", ge, (kind >= 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    int rises;
    logic prev, all_high;
    realtime t1, t2;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(tgt_rst_n && !data_oe && !clk_oe && !link_clk && !tx_ready && !rx_valid,
        "R12 reset state", {tgt_rst_n, data_oe, clk_oe, link_clk, tx_ready, rx_valid}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    session_en = 1'b1;
    @(negedge clk);
    chk(!tgt_rst_n, "R6 reset low on entry", tgt_rst_n, 0);
    rises = 0; prev = link_clk; all_high = 1'b1;
    for (int k = 0; k < 2000 && !tx_ready; k++) begin
      @(negedge clk);
      if (link_clk && !prev) begin
        rises++;
        if (!(data_out && data_oe)) all_high = 1'b0;
      end
      prev = link_clk;
    end
    chk(tx_ready && rises >= 24 && all_high, "R6 idle frames before ready", rises, 24);

    // R11 link clock period
    @(posedge link_clk); t1 = $realtime;
    @(posedge link_clk); t2 = $realtime;
    chk((t2 - t1) == 2.0*HD*5.0, "R11 link clock period", int'(t2 - t1), 2*HD*5);

    // vector table
    foreach (VEC[i]) begin
      int kind;
      kind = int'(VEC[i][11:10]);
      if (kind == 0) do_tx(VEC[i][7:0]);
      else do_rx(VEC[i][7:0], kind, int'(VEC[i][9:8]) + 1);
    end

    // R10 idle frame request
    begin
      logic ok;
      ok = 1'b1;
      @(negedge clk);
      wait_ready();
      idle_req = 1'b1;
      @(negedge clk);
      idle_req = 1'b0;
      chk(!tx_ready, "R8 busy after idle accept", tx_ready, 0);
      for (int i = 0; i < FW; i++) begin
        @(posedge link_clk); #1;
        if (!(data_out && data_oe)) ok = 1'b0;
      end
      chk(ok, "R10 idle frame held high", ok, 1);
    end

    // R7 exit
    @(negedge clk);
    wait_ready();
    session_en = 1'b0;
    @(negedge clk);
    chk(tgt_rst_n && !data_oe && !clk_oe && !link_clk, "R7 exit releases lines",
        {tgt_rst_n, data_oe, clk_oe, link_clk}, 4'b1000);
    repeat (3*HD) @(negedge clk);
    chk(!link_clk && !tx_ready, "R7 clock parked after exit", {link_clk, tx_ready}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule